// File: doc/BRIEF.md
# Frame Triplet Capture Controller

This controller sits on the capture side of a camera frame grabber. Frames arrive from the sensor side as single-beat events and are grouped into triplets of three. The controller holds one triplet at a time and tells the host which frame of that triplet should be moved next. It also reports whether the last transfer has finished. When a new triplet starts while the held one still has frames in it, the whole new triplet is thrown away and a saturating counter records the loss. The DMA datapath is outside the block: the host signals the start of a transfer with `xfer_start` and the engine reports the end with `xfer_done`.

The host sees four 32-bit registers at offsets 0x0 (frame size in 4096-byte pages, read-only), 0x4 (control, bit 0 = enable), 0x8 (status) and 0xC (probe presence). Status bits 1:0 give the 1-based index of the next pending frame, with 0 meaning none. Bit 2 is the transfer-complete flag. Bits 15:8 are the discarded-triplet count. The interrupt request is a level: it stays high while the controller is enabled and there is work for the host.

Frame input handshake: a frame is taken on a cycle where `frm_valid` and `frm_ready` are both high. `frm_ready` equals the enable bit. The source has no other way to be stalled: frames offered while the controller is disabled are lost, and a full slot causes a discard, not back-pressure.

Top module: `triplet_capture_ctrl`

## Requirements
- R1: After reset, `irq`, `frm_ready` and `reg_rdata` are 0, and the control and status registers read 0.
- R2: Reading offset 0x0 returns the parameter `FRAME_PAGES`. A write to 0x0 does not change it.
- R3: Bit 0 of offset 0x4 is the enable bit. It reads back as written, holds its value when not written, and drives `frm_ready`.
- R4: Status bits 1:0 give the 1-based index of the next frame of the held triplet that is buffered and not yet started. They read 0 when no such frame exists or a transfer is in flight. An `xfer_start` with nothing pending is ignored.
- R5: Frames of a triplet are offered for transfer in the order 1, 2, 3. Completing the third transfer empties the slot.
- R6: Status bit 2 is set by `xfer_done` ending a transfer. It is cleared when the host starts the next transfer.
- R7: When the first frame of a triplet arrives while the slot still holds frames, all three frames of that triplet are dropped, and status bits 15:8 increase by one. The held triplet is not disturbed.
- R8: The discard count saturates at 255.
- R9: A read of offset 0x8 returns the count before clearing, and the count is 0 afterwards.
- R10: Offset 0xC bit 0 reflects `probe_present` (1 = attached).
- R11: Clearing the enable bit empties the slot and clears the in-flight transfer and the complete flag. After re-enabling, the next frame taken is frame 1 of a new triplet.
- R12: `irq` is high exactly when enabled and either status bits 1:0 are non-zero or the complete flag is set.
- R13: Read data appears on `reg_rdata` one cycle after `reg_rd`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |
| frm_valid | input | 1 | Frame offered by the sensor side |
| frm_ready | output | 1 | Frame accepted this cycle when high |
| xfer_start | input | 1 | Host started a frame transfer |
| xfer_done | input | 1 | Transfer completion pulse |
| probe_present | input | 1 | Probe attach detect |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle, the embedded assertions check the following: the completion order and the freeing of the slot after the third transfer, the clearing and setting of the complete flag, the flush while disabled, the counter's increment, saturation and clear, and the stability of the enable bit. Some behaviour only the directed scenarios can show. These are the register values seen by the host: the exact status words across a full triplet, that a discarded triplet leaves the held one intact in order, that a partial triplet restarts at frame 1 after a disable, and the interrupt level in each phase.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] OFF_FSIZE = 4'h0;
  localparam logic [REG_AW-1:0] OFF_CTRL  = 4'h4;
  localparam logic [REG_AW-1:0] OFF_STAT  = 4'h8;
  localparam logic [REG_AW-1:0] OFF_PROBE = 4'hC;
  localparam int STS_IDX_LSB = 0;
  localparam int STS_DONE    = 2;
  localparam int STS_CNT_LSB = 8;
endpackage

// File: rtl/tcc_sat_cnt.sv
module tcc_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= inc ? W'(1) : '0;
    else if (inc && cnt != MAXV) cnt <= cnt + 1'b1;
  end

  AST_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && cnt != MAXV) |=> cnt == $past(cnt) + 1'b1); // R7
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && !clr) |=> cnt == MAXV); // R8
  AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> cnt == '0); // R9
endmodule

// File: rtl/tcc_slot.sv
module tcc_slot #(
  parameter int TRIP_LEN = 3,
  parameter int NUM_W    = $clog2(TRIP_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             frm_fire,
  input  logic             xfer_start,
  input  logic             xfer_done,
  output logic [NUM_W-1:0] next_idx,
  output logic             done_flag,
  output logic             trip_drop
);
  localparam int POS_W = $clog2(TRIP_LEN);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(TRIP_LEN - 1);
  localparam logic [NUM_W-1:0] RD_LAST  = NUM_W'(TRIP_LEN - 1);

  logic [POS_W-1:0] in_pos;
  logic             in_drop;
  logic [NUM_W-1:0] wr_cnt, rd_cnt;
  logic             busy;
  logic             first, slot_empty, take, start_ok, finish, last_rd, pend;

  always_comb begin
    first      = (in_pos == '0);
    slot_empty = (wr_cnt == '0);
    take       = frm_fire && (first ? slot_empty : !in_drop);
    pend       = !busy && (wr_cnt > rd_cnt);
    start_ok   = xfer_start && pend;
    finish     = xfer_done && busy;
    last_rd    = (rd_cnt == RD_LAST);
    trip_drop  = frm_fire && first && !slot_empty;
    next_idx   = pend ? rd_cnt + 1'b1 : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      in_pos    <= '0;
      in_drop   <= 1'b0;
      wr_cnt    <= '0;
      rd_cnt    <= '0;
      busy      <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      if (frm_fire) begin
        in_pos <= (in_pos == POS_LAST) ? '0 : in_pos + 1'b1;
        if (first) in_drop <= !slot_empty;
      end
      if (take) wr_cnt <= wr_cnt + 1'b1;
      if (start_ok) begin
        busy      <= 1'b1;
        done_flag <= 1'b0;
      end
      if (finish) begin
        busy      <= 1'b0;
        done_flag <= 1'b1;
        if (last_rd) begin
          rd_cnt <= '0;
          wr_cnt <= '0;
        end else begin
          rd_cnt <= rd_cnt + 1'b1;
        end
      end
    end
  end

  AST_ORDER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && finish && !last_rd) |=> rd_cnt == $past(rd_cnt) + 1'b1); // R5
  AST_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && finish && last_rd) |=> (wr_cnt == '0 && rd_cnt == '0)); // R5
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (en && finish) |=> done_flag); // R6
  AST_DONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start_ok) |=> !done_flag); // R6
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (next_idx == '0 && !done_flag && in_pos == '0)); // R11
endmodule

// File: rtl/tcc_regs.sv
module tcc_regs
  import tcc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_W       = 2,
  parameter int CNT_W       = 8,
  parameter int FRAME_PAGES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NUM_W-1:0]  next_idx,
  input  logic              done_flag,
  input  logic [CNT_W-1:0]  drop_cnt,
  input  logic              probe_present,
  output logic              en,
  output logic              cnt_clr,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [DATA_W-1:0] rd_mux, sts_word;

  always_comb begin
    sts_word = '0;
    sts_word[STS_IDX_LSB +: NUM_W] = next_idx;
    sts_word[STS_DONE]             = done_flag;
    sts_word[STS_CNT_LSB +: CNT_W] = drop_cnt;
    unique case (reg_addr)
      OFF_FSIZE: rd_mux = DATA_W'(FRAME_PAGES);
      OFF_CTRL:  rd_mux = DATA_W'(en);
      OFF_STAT:  rd_mux = sts_word;
      OFF_PROBE: rd_mux = DATA_W'(probe_present);
      default:   rd_mux = '0;
    endcase
    cnt_clr = reg_rd && (reg_addr == OFF_STAT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == OFF_CTRL) en <= reg_wdata[0];
      reg_rdata <= reg_rd ? rd_mux : '0;
    end
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(en)); // R3
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> reg_rdata == '0); // R13
endmodule

// File: rtl/triplet_capture_ctrl.sv
module triplet_capture_ctrl
  import tcc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int TRIP_LEN    = 3,
  parameter int CNT_W       = 8,
  parameter int FRAME_PAGES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic              xfer_start,
  input  logic              xfer_done,
  input  logic              probe_present,
  output logic              irq
);
  localparam int NUM_W = $clog2(TRIP_LEN + 1);

  logic             en, cnt_clr, done_flag, trip_drop;
  logic [NUM_W-1:0] next_idx;
  logic [CNT_W-1:0] drop_cnt;

  assign frm_ready = en;
  assign irq       = en && ((next_idx != '0) || done_flag);

  tcc_slot #(.TRIP_LEN(TRIP_LEN), .NUM_W(NUM_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .en(en),
    .frm_fire(frm_valid && frm_ready),
    .xfer_start(xfer_start), .xfer_done(xfer_done),
    .next_idx(next_idx), .done_flag(done_flag), .trip_drop(trip_drop)
  );

  tcc_sat_cnt #(.W(CNT_W)) u_drop (
    .clk(clk), .rst_n(rst_n), .inc(trip_drop), .clr(cnt_clr), .cnt(drop_cnt)
  );

  tcc_regs #(.DATA_W(DATA_W), .NUM_W(NUM_W), .CNT_W(CNT_W),
             .FRAME_PAGES(FRAME_PAGES)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .next_idx(next_idx),
    .done_flag(done_flag), .drop_cnt(drop_cnt), .probe_present(probe_present),
    .en(en), .cnt_clr(cnt_clr), .reg_rdata(reg_rdata)
  );

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !en) |=> !irq); // R12
endmodule

// File: tb/triplet_capture_ctrl_tb.sv
`timescale 1ns/1ps
module triplet_capture_ctrl_tb;
  localparam int PAGES = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        frm_valid = 1'b0, frm_ready;
  logic        xfer_start = 1'b0, xfer_done = 1'b0;
  logic        probe_present = 1'b0, irq;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  triplet_capture_ctrl #(.FRAME_PAGES(PAGES)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .xfer_start(xfer_start),
    .xfer_done(xfer_done), .probe_present(probe_present), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic frame();
    @(negedge clk); frm_valid = 1'b1;
    @(negedge clk); frm_valid = 1'b0;
  endtask

  task automatic start_x();
    @(negedge clk); xfer_start = 1'b1;
    @(negedge clk); xfer_start = 1'b0;
  endtask

  task automatic done_x();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic flush();
    wr(4'h0 + 4'h4, 32'h0);
    wr(4'h4, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 frm_ready", {31'b0, frm_ready}, 32'h0);
    chk("R1 rdata", reg_rdata, 32'h0);
    rd(4'h4, d); chk("R1 ctrl", d, 32'h0);
    rd(4'h8, d); chk("R1 status", d, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    rd(4'h0, d); chk("R2 frame size", d, PAGES);
    wr(4'h0, 32'h55);
    rd(4'h0, d); chk("R2 read-only", d, PAGES);
    probe_present = 1'b1;
    rd(4'hC, d); chk("R10 probe on", d, 32'h1);
    probe_present = 1'b0;
    rd(4'hC, d); chk("R10 probe off", d, 32'h0);
    rd(4'h1, d); chk("R13 unmapped", d, 32'h0);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 4'h0;
    #1 chk("R13 latency before edge", reg_rdata, 32'h0);
    @(negedge clk); reg_rd = 1'b0;
    chk("R13 latency after edge", reg_rdata, PAGES);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(4'h4, 32'h1);
    rd(4'h4, d); chk("R3 ctrl readback", d, 32'h1);
    chk("R3 frm_ready", {31'b0, frm_ready}, 32'h1);
    rd(4'h4, d); chk("R3 ctrl holds", d, 32'h1);
  endtask

  task automatic t_idle_start();
    logic [31:0] d;
    flush();
    start_x();
    frame();
    rd(4'h8, d); chk("R4 idle start ignored", d, 32'h1);
  endtask

  task automatic t_triplet();
    logic [31:0] d;
    flush();
    chk("R12 irq idle", {31'b0, irq}, 32'h0);
    frame(); frame(); frame();
    rd(4'h8, d); chk("R4 first pending", d, 32'h1);
    chk("R12 irq pending", {31'b0, irq}, 32'h1);
    start_x();
    rd(4'h8, d); chk("R4 in flight", d, 32'h0);
    chk("R12 irq in flight", {31'b0, irq}, 32'h0);
    done_x();
    rd(4'h8, d); chk("R5 R6 after frame1", d, 32'h6);
    start_x();
    rd(4'h8, d); chk("R6 cleared by start", d, 32'h0);
    done_x();
    rd(4'h8, d); chk("R5 after frame2", d, 32'h7);
    start_x(); done_x();
    rd(4'h8, d); chk("R5 slot freed", d, 32'h4);
    chk("R12 irq on done", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_discard();
    logic [31:0] d;
    flush();
    frame(); frame(); frame();
    frame(); frame(); frame();
    rd(4'h8, d); chk("R7 discard counted", d, 32'h101);
    rd(4'h8, d); chk("R9 clear on read", d, 32'h1);
    start_x(); done_x();
    rd(4'h8, d); chk("R7 held triplet intact", d, 32'h6);
  endtask

  task automatic t_saturate();
    logic [31:0] d;
    flush();
    frame(); frame(); frame();
    for (int i = 0; i < 260; i++) begin
      frame(); frame(); frame();
    end
    rd(4'h8, d); chk("R8 saturated", d, 32'hFF01);
    rd(4'h8, d); chk("R9 cleared after saturation", d, 32'h1);
  endtask

  task automatic t_disable_mid();
    logic [31:0] d;
    flush();
    frame(); start_x(); done_x();
    frame();
    wr(4'h4, 32'h0);
    rd(4'h8, d); chk("R11 flushed status", d, 32'h0);
    chk("R11 irq off", {31'b0, irq}, 32'h0);
    chk("R11 ready off", {31'b0, frm_ready}, 32'h0);
    frame();
    wr(4'h4, 32'h1);
    rd(4'h8, d); chk("R11 disabled frame ignored", d, 32'h0);
    frame(); frame();
    rd(4'h8, d); chk("R11 restart at frame 1", d, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_enable();
    t_idle_start();
    t_triplet();
    t_discard();
    t_saturate();
    t_disable_mid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule